// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous static memory with a flow-through read path and no bus turnaround cycle. It is addressed in bursts of four. Control inputs are registered on the rising clock edge. On each enabled edge the core classifies the cycle as one of four kinds: a load that starts a read or write burst, a step that continues the burst in progress, a deselect, or a clock hold that freezes everything. A 2-bit step counter rewrites the two low address bits in either linear or XOR-interleaved order. The upper address bits stay as they were loaded.

Read data for the address registered at one edge appears combinationally on the shared data bus before the next edge. Write data is taken from the bus at the next enabled edge. A host can therefore alternate reads and writes on consecutive cycles without inserting idle cycles. The word is split into independently writable lanes. A write with every lane disabled touches nothing.

Top module: `sbs_core`

## Requirements
- R1: When the clock enable `clk_en_n` is 0, `advance` is 0, and the chip is selected, the cycle is a load. Selection means `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A load registers `addr` as the current address. `rd_wr_n`=1 starts a read burst and `rd_wr_n`=0 starts a write burst.
- R2: A load cycle with any chip select inactive is a deselect. While deselected the data bus is high-impedance. Step cycles that follow a deselect, or that follow reset, keep the core deselected.
- R3: A step cycle is one with `advance`=1 and `clk_en_n`=0. It keeps the burst type chosen at the last load or deselect and ignores `rd_wr_n`.
- R4: When `interleave` was 0 at the load, each step adds 1 modulo 4 to the two low address bits. For example, a start of 01 gives 01, 10, 11, 00. The fifth access returns to the start address, and the upper bits never change.
- R5: When `interleave` was 1 at the load, step k accesses the start low bits XOR k. For example, a start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01. The order is latched at the load, so `interleave` is ignored on step cycles.
- R6: `lane_wr_n[0]`=0 enables writes to `data[8:0]`, and `lane_wr_n[1]`=0 enables writes to `data[17:9]`. The lane enables are sampled with each write access. If both are 1 (a write abort), no location changes and the bus stays high-impedance.
- R7: For a read, the word at the address registered at edge N drives the bus after edge N and before edge N+1. For a write, the address is registered at edge N and the data is sampled at the next enabled edge, so a read of the same location immediately afterwards returns the new word.
- R8: `out_en` gates the read drivers combinationally. A read with `out_en`=0 is a dummy read: the bus is high-impedance, but the burst address still advances.
- R9: During a write burst the core never drives the bus, whatever the level of `out_en`.
- R10: `clk_en_n`=1 is a hold cycle. No register changes and no write takes place. The bus stays driven if a read is current and stays high-impedance if a write is current. A pending write completes at the next enabled edge with the data present at that edge.
- R11: Synchronous active-high `rst` puts the core in the deselected state, with the bus high-impedance. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every control input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| advance | input | 1 | 1 steps the current burst, 0 loads a new address |
| rd_wr_n | input | 1 | Burst type on a load: 1 read, 0 write |
| lane_wr_n | input | LANES (2) | Per-lane write enables, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 holds all state |
| out_en | input | 1 | Read output enable, active high, combinational |
| interleave | input | 1 | Burst order on a load: 1 XOR-interleaved, 0 linear |
| addr | input | ADDR_W (8) | Word address |
| data | inout | LANES*LANE_W (18) | Shared read/write data bus |

## Verification
The properties assume that the host drives the data bus only in the cycle after a write access is registered, and releases it shortly after the sampling edge. This means the core's read drivers never fight the host at a sampling instant. The stimulus applies every control change at the falling edge and removes its write data one time unit after the rising edge, so the bus is quiet whenever the bench samples it. A pull-up on every bus bit makes the high-impedance state visible as all ones. For that reason, no stored word that is read back equals all ones.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Burst type held between load cycles
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } burst_op_e;

    // Classification of one clock cycle
    typedef enum logic [1:0] {
        CY_HOLD = 2'd0,
        CY_IDLE = 2'd1,
        CY_LOAD = 2'd2,
        CY_STEP = 2'd3
    } cycle_e;

    // Burst control state
    typedef struct packed {
        burst_op_e  op;
        logic       ilv;
        logic [1:0] step;
    } burst_ctl_t;

    // Low address bits for a given step of a four-beat burst
    function automatic logic [1:0] seq_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
(
    input  logic   cs0_n,
    input  logic   cs1,
    input  logic   cs2_n,
    input  logic   advance,
    input  logic   clk_en_n,
    output cycle_e kind
);
    logic selected;

    assign selected = !cs0_n && cs1 && !cs2_n;

    always_comb begin
        if (clk_en_n)
            kind = CY_HOLD;
        else if (advance)
            kind = CY_STEP;
        else if (selected)
            kind = CY_LOAD;
        else
            kind = CY_IDLE;
    end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cycle_e            kind,
    input  logic              rd_wr_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wr_n,
    output burst_op_e         op,
    output logic              burst_ilv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  lane_en
);
    burst_ctl_t        ctl;
    logic [ADDR_W-1:0] base;
    logic [LANES-1:0]  lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '{op: OP_IDLE, ilv: 1'b0, step: 2'd0};
            base   <= '0;
            lane_q <= '0;
        end else begin
            case (kind)
                CY_LOAD: begin
                    ctl.op   <= rd_wr_n ? OP_READ : OP_WRITE;
                    ctl.ilv  <= interleave;
                    ctl.step <= 2'd0;
                    base     <= addr;
                    lane_q   <= ~lane_wr_n;
                end
                CY_IDLE: begin
                    ctl.op   <= OP_IDLE;
                    ctl.step <= 2'd0;
                    lane_q   <= '0;
                end
                CY_STEP: begin
                    if (ctl.op != OP_IDLE) begin
                        ctl.step <= ctl.step + 2'd1;
                        lane_q   <= ~lane_wr_n;
                    end
                end
                default: ;
            endcase
        end
    end

    assign op        = ctl.op;
    assign burst_ilv = ctl.ilv;
    assign lane_en   = lane_q;
    assign cur_addr  = {base[ADDR_W-1:2], seq_low(base[1:0], ctl.step, ctl.ilv)};
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sbs_core.sv
module sbs_core
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs0_n,
    input  logic                         cs1,
    input  logic                         cs2_n,
    input  logic                         advance,
    input  logic                         rd_wr_n,
    input  logic [LANES-1:0]             lane_wr_n,
    input  logic                         clk_en_n,
    input  logic                         out_en,
    input  logic                         interleave,
    input  logic [ADDR_W-1:0]            addr,
    inout  wire  logic [LANES*LANE_W-1:0] data
);
    localparam int DATA_W = LANES * LANE_W;

    cycle_e            kind;
    burst_op_e         op;
    logic              burst_ilv;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] rd_word;
    logic              wr_go;
    logic              bus_drive;

    sbs_decode u_decode (
        .cs0_n    (cs0_n),
        .cs1      (cs1),
        .cs2_n    (cs2_n),
        .advance  (advance),
        .clk_en_n (clk_en_n),
        .kind     (kind)
    );

    sbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .rd_wr_n    (rd_wr_n),
        .interleave (interleave),
        .addr       (addr),
        .lane_wr_n  (lane_wr_n),
        .op         (op),
        .burst_ilv  (burst_ilv),
        .cur_addr   (cur_addr),
        .lane_en    (lane_en)
    );

    // The write of the access registered last cycle lands on this enabled edge
    assign wr_go = (op == OP_WRITE) && !clk_en_n && !rst;

    sbs_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .we      (wr_go),
        .lane_en (lane_en),
        .waddr   (cur_addr),
        .wdata   (data),
        .raddr   (cur_addr),
        .rdata   (rd_word)
    );

    assign bus_drive = (op == OP_READ) && out_en;
    assign data      = bus_drive ? rd_word : {DATA_W{1'bz}};
endmodule

// File: rtl/sbs_core_chk.sv
module sbs_core_chk
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs0_n,
    input logic              cs1,
    input logic              cs2_n,
    input logic              advance,
    input logic              clk_en_n,
    input logic              out_en,
    input logic [ADDR_W-1:0] addr,
    input burst_op_e         op,
    input logic              burst_ilv,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              bus_drive
);
    logic sel;
    assign sel = !cs0_n && cs1 && !cs2_n;

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !advance && sel) |=> (cur_addr == $past(addr))); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |-> !bus_drive); // R2

    AST_STEP_KEEPS_TYPE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && advance) |=> (op == $past(op))); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && advance && op != OP_IDLE && !burst_ilv)
        |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)
            && (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R4

    AST_ILV_FLIPS_LSB: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && advance && op != OP_IDLE && burst_ilv)
        |=> (cur_addr[0] != $past(cur_addr[0])) && $stable(burst_ilv)); // R5

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> out_en); // R8

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |-> !bus_drive); // R9

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(cur_addr) && (op == $past(op))); // R10
endmodule

bind sbs_core sbs_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs0_n     (cs0_n),
    .cs1       (cs1),
    .cs2_n     (cs2_n),
    .advance   (advance),
    .clk_en_n  (clk_en_n),
    .out_en    (out_en),
    .addr      (addr),
    .op        (op),
    .burst_ilv (burst_ilv),
    .cur_addr  (cur_addr),
    .bus_drive (bus_drive)
);

// File: tb/test_sbs_core.sv
`timescale 1ns/1ps
module test_sbs_core;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 18;
    localparam logic [DW-1:0] ZVAL = 18'h3FFFF; // pulled-up bus

    typedef struct packed {
        logic [2:0]    cs;   // {cs0_n, cs1, cs2_n}
        logic          adv;
        logic          rd;
        logic [1:0]    bwn;
        logic          ckn;
        logic          oe;
        logic          il;
        logic [AW-1:0] a;
        logic          drv;
        logic [DW-1:0] dv;
        logic          xz;
        logic [DW-1:0] xv;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{3'b010,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,8'h21,1'b0,18'h00000,1'b1,18'h00000,4'd9},  // R9 write load, oe high
        '{3'b010,1'b1,1'b0,2'b00,1'b0,1'b1,1'b0,8'h00,1'b1,18'h12345,1'b1,18'h00000,4'd3},  // R3
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b1,18'h0AAAA,1'b1,18'h00000,4'd3},  // R3 rd ignored
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b1,18'h15555,1'b1,18'h00000,4'd3},
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h21,1'b1,18'h00111,1'b0,18'h12345,4'd7},  // R7 write then read
        '{3'b010,1'b1,1'b0,2'b11,1'b0,1'b1,1'b1,8'h00,1'b0,18'h00000,1'b0,18'h0AAAA,4'd4},  // R4 linear
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h15555,4'd4},
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h00111,4'd4},
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h12345,4'd4},  // R4 wrap
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b1,8'h21,1'b0,18'h00000,1'b0,18'h12345,4'd5},  // R5 interleaved
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h00111,4'd5},
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h15555,4'd5},
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h0AAAA,4'd5},
        '{3'b010,1'b0,1'b0,2'b10,1'b0,1'b1,1'b0,8'h22,1'b0,18'h00000,1'b1,18'h00000,4'd6},  // R6 low lane only
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h22,1'b1,18'h3FFFF,1'b0,18'h0ABFF,4'd6},
        '{3'b010,1'b0,1'b0,2'b11,1'b0,1'b1,1'b0,8'h23,1'b0,18'h00000,1'b1,18'h00000,4'd6},  // R6 abort
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h23,1'b1,18'h00000,1'b0,18'h15555,4'd6},
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,8'h20,1'b0,18'h00000,1'b1,18'h00000,4'd8},  // R8 dummy read
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h12345,4'd8},  // R8 advanced
        '{3'b110,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h21,1'b0,18'h00000,1'b1,18'h00000,4'd2},  // R2 deselect
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b1,18'h00000,4'd2},  // R2 continue
        '{3'b010,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,8'h30,1'b0,18'h00000,1'b1,18'h00000,4'd9},
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h30,1'b1,18'h2468A,1'b0,18'h2468A,4'd7},  // R7 back to back
        '{3'b010,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,8'h31,1'b0,18'h00000,1'b1,18'h00000,4'd9},
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b1,18'h13579,1'b1,18'h00000,4'd3},  // R3 stays write
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h31,1'b1,18'h3C3C3,1'b0,18'h13579,4'd3},
        '{3'b010,1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h3C3C3,4'd3},
        '{3'b010,1'b0,1'b0,2'b00,1'b1,1'b1,1'b0,8'h00,1'b0,18'h00000,1'b0,18'h3C3C3,4'd10}, // R10 hold on read
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h21,1'b0,18'h00000,1'b0,18'h12345,4'd10},
        '{3'b010,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,8'h34,1'b0,18'h00000,1'b1,18'h00000,4'd9},
        '{3'b010,1'b1,1'b1,2'b00,1'b1,1'b1,1'b0,8'h00,1'b1,18'h11111,1'b1,18'h00000,4'd10}, // R10 hold on write
        '{3'b010,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,8'h34,1'b1,18'h22222,1'b0,18'h22222,4'd10}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cs = 3'b110;
    logic          advance = 1'b0;
    logic          rd_wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          clk_en_n = 1'b0;
    logic          out_en = 1'b1;
    logic          interleave = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          tb_drv = 1'b0;
    logic [DW-1:0] tb_val = '0;
    wire  [DW-1:0] dq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dq = tb_drv ? tb_val : {DW{1'bz}};
    for (genvar gi = 0; gi < DW; gi++) begin : g_pull
        pullup (dq[gi]);
    end

    sbs_core i_sbs_core (
        .clk        (clk),
        .rst        (rst),
        .cs0_n      (cs[2]),
        .cs1        (cs[1]),
        .cs2_n      (cs[0]),
        .advance    (advance),
        .rd_wr_n    (rd_wr_n),
        .lane_wr_n  (lane_wr_n),
        .clk_en_n   (clk_en_n),
        .out_en     (out_en),
        .interleave (interleave),
        .addr       (addr),
        .data       (dq)
    );

    task automatic check(input logic xz, input logic [DW-1:0] xv, input int rq, input string what);
        logic [DW-1:0] exp;
        exp = xz ? ZVAL : xv;
        total++;
        if (dq !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %h expected %h%s", rq, what, dq, exp, xz ? " (high-Z)" : "");
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input logic [2:0] c, input logic adv, input logic rd, input logic [1:0] bwn,
                        input logic ckn, input logic oe, input logic il, input logic [AW-1:0] a,
                        input logic drv, input logic [DW-1:0] dv);
        cs = c; advance = adv; rd_wr_n = rd; lane_wr_n = bwn;
        clk_en_n = ckn; out_en = oe; interleave = il; addr = a;
        tb_drv = drv; tb_val = dv;
        @(posedge clk);
        #1 tb_drv = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b1, '0, 11, "bus idle in reset");                         // R11
        rst = 1'b0;
        step(3'b010, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, '0);
        check(1'b1, '0, 2, "continue after reset stays deselected");      // R2

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].cs, VECS[i].adv, VECS[i].rd, VECS[i].bwn, VECS[i].ckn,
                 VECS[i].oe, VECS[i].il, VECS[i].a, VECS[i].drv, VECS[i].dv);
            check(VECS[i].xz, VECS[i].xv, int'(VECS[i].rq), $sformatf("vector %0d", i));
        end

        // R2: each chip select alone deselects
        step(3'b110, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h21, 1'b0, '0);
        check(1'b1, '0, 2, "cs0_n high");
        step(3'b000, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h21, 1'b0, '0);
        check(1'b1, '0, 2, "cs1 low");
        step(3'b011, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h21, 1'b0, '0);
        check(1'b1, '0, 2, "cs2_n high");
        step(3'b010, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h21, 1'b0, '0);
        check(1'b0, 18'h12345, 1, "selected load read");                  // R1

        // R8: out_en acts without a clock edge
        out_en = 1'b0;
        #2 check(1'b1, '0, 8, "out_en low mid-cycle");
        out_en = 1'b1;
        #2 check(1'b0, 18'h12345, 8, "out_en back high");
        @(negedge clk);

        // R5: interleaved from 10, order latched at load
        step(3'b010, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, '0);
        check(1'b0, 18'h0ABFF, 5, "ilv start 10 beat 0");
        step(3'b010, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, '0);
        check(1'b0, 18'h15555, 5, "ilv beat 1 (11)");
        step(3'b010, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, '0);
        check(1'b0, 18'h00111, 5, "ilv beat 2 (00)");
        step(3'b010, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, '0);
        check(1'b0, 18'h12345, 5, "ilv beat 3 (01)");

        // R11: reset in the middle of a read burst
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1'b1, '0, 11, "reset during read burst");
        rst = 1'b0;
        step(3'b010, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h30, 1'b0, '0);
        check(1'b0, 18'h2468A, 11, "array kept through reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule